// File: doc/BRIEF.md
# UV-Erasable Byte ROM Behavioural Model

This block is a synthesizable stand-in for a byte-wide, electrically programmed and light-erased read-only memory, meant to sit on the far side of a memory controller inside a testbench. The external voltages are reduced to digital flags: one flag says the programming supply is raised, another says the identifier select pin is driven to its elevated level. The model decodes the classic pin-level modes from these flags and the two active-low controls. The modes are standby, output disable, read, identifier read, program and program inhibit.

Storage starts fully erased with every bit at 1. A program pulse is a low period on the chip-enable input with the programming flag held high. The pulse commits when chip-enable returns high and can only clear bits, because the new byte is ANDed into the old one. Only the erase input sets bits back to 1, and it does so for the whole array in one clock. The data path is a plain pin-level interface with no valid/ready handshake and no back-pressure. Read data is a combinational function of the current pins and the stored array. A controller must therefore hold its pins for as long as it wants the value. `dout_oe` stands in for the tri-state enable, and `dout` is forced to zero whenever the enable is low.

Top module: `uvrom_model`

## Requirements
- R1: After reset every stored byte reads as FFh, and the outputs are disabled while chip-enable is high.
- R2: With `ce_n` high the block is in standby: `dout_oe` is 0 and `dout` is 0, whatever `oe_n`, `vpp_hi` and `id_hv` are.
- R3: With `ce_n` low, `oe_n` low and `vpp_hi` low, and not in identifier mode, `dout_oe` is 1 and `dout` equals the byte stored at `addr` in the same cycle.
- R4: With `ce_n` low, `vpp_hi` low and `oe_n` high, `dout_oe` is 0.
- R5: While `vpp_hi` is high and `ce_n` is low, `dout_oe` is 0. A program pulse is `ce_n` low for at least one clock edge with `vpp_hi` high at every edge of the pulse. At the first clock edge where `ce_n` is sampled high again with `vpp_hi` still high, the byte at the address sampled at the last low edge becomes the old byte AND the data sampled at that edge.
- R6: Programming never turns a 0 bit into a 1.
- R7: No write occurs when `vpp_hi` is high but `ce_n` stays high (program inhibit). No write occurs when `vpp_hi` falls before `ce_n` rises (aborted pulse).
- R8: `erase` high at a clock edge sets every byte to FFh. If a program commit falls on the same edge, the erase takes precedence.
- R9: With read conditions (`ce_n`, `oe_n` and `vpp_hi` low), `id_hv` high and every address bit other than bit 0 and bit `ID_BIT` low, `dout_oe` is 1. `dout` is then 20h when `addr[0]` is 0 and 3Dh when `addr[0]` is 1.
- R10: With `id_hv` high but another address bit (neither bit 0 nor bit `ID_BIT`) set, a read returns the stored array byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for program commit, erase and pulse tracking |
| rst_n | input | 1 | Active-low asynchronous reset, erases the array |
| addr | input | ADDR_W (10) | Byte address |
| ce_n | input | 1 | Active-low chip enable, also the program strobe |
| oe_n | input | 1 | Active-low output enable |
| vpp_hi | input | 1 | Programming supply raised on the output-enable pin |
| id_hv | input | 1 | Identifier select pin at its elevated level |
| erase | input | 1 | Whole-array erase to all ones |
| din | input | DATA_W (8) | Data to program |
| dout | output | DATA_W (8) | Read data, zero when not driven |
| dout_oe | output | 1 | Output drive enable (tri-state control) |

## Verification
The bench builds the block with its defaults: a 10-bit address, so 1024 bytes, and the identifier select bit at bit 9, the top address bit. With that size, random addresses revisit the same bytes often enough that repeated programming exposes the clear-only rule. The one-cycle erase is checked against every one of the 1024 cells. With the select bit at the top of the address, identifier reads are mixed with reads of upper-half addresses that carry bit 9. The directed cases cover an erase that lands on the same edge as a commit, an aborted pulse and an inhibited pulse.

// File: rtl/uvrom_pkg.sv
package uvrom_pkg;
  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_DISABLE,
    MODE_READ,
    MODE_IDENT,
    MODE_PROGRAM
  } rom_mode_e;
endpackage

// File: rtl/uvrom_mode_dec.sv
module uvrom_mode_dec
  import uvrom_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int ID_BIT = 9
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic [ADDR_W-1:0] addr,
  output rom_mode_e         mode
);
  localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ID_MASK = ~(ONE | (ONE << ID_BIT));

  logic others_low;
  assign others_low = ((addr & ID_MASK) == '0);

  always_comb begin
    if (ce_n)                     mode = MODE_STANDBY;
    else if (vpp_hi)              mode = MODE_PROGRAM;
    else if (oe_n)                mode = MODE_DISABLE;
    else if (id_hv && others_low) mode = MODE_IDENT;
    else                          mode = MODE_READ;
  end
endmodule

// File: rtl/uvrom_prog_ctl.sv
module uvrom_prog_ctl #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              vpp_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic              armed_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // A pulse stays armed only while every edge sees ce_n low and vpp_hi high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      armed_q <= !ce_n && vpp_hi;
      if (!ce_n && vpp_hi) begin
        addr_q <= addr;
        data_q <= din;
      end
    end
  end

  // Commit on the edge where chip enable is seen high again with supply up.
  assign wr_en   = armed_q && ce_n && vpp_hi;
  assign wr_addr = addr_q;
  assign wr_data = data_q;
endmodule

// File: rtl/uvrom_cells.sv
module uvrom_cells #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH*DATA_W-1:0] flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '1;
      else if (erase)
        word_q <= '1;
      else if (wr_en && (wr_addr == ADDR_W'(g)))
        word_q <= word_q & wr_data;
    end
    assign flat[g*DATA_W +: DATA_W] = word_q;
  end

  assign rd_data = flat[int'(rd_addr)*DATA_W +: DATA_W];
endmodule

// File: rtl/uvrom_model.sv
module uvrom_model
  import uvrom_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int ID_BIT = 9,
  parameter logic [DATA_W-1:0] MFR_CODE = DATA_W'(8'h20),
  parameter logic [DATA_W-1:0] DEV_CODE = DATA_W'(8'h3D)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic              erase,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  rom_mode_e         mode;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  uvrom_mode_dec #(.ADDR_W(ADDR_W), .ID_BIT(ID_BIT)) u_dec (
    .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi), .id_hv(id_hv),
    .addr(addr), .mode(mode)
  );

  uvrom_prog_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_prog (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .vpp_hi(vpp_hi),
    .addr(addr), .din(din),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  uvrom_cells #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cells (
    .clk(clk), .rst_n(rst_n), .erase(erase),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(addr), .rd_data(rd_data)
  );

  always_comb begin
    dout    = '0;
    dout_oe = 1'b0;
    case (mode)
      MODE_READ: begin
        dout    = rd_data;
        dout_oe = 1'b1;
      end
      MODE_IDENT: begin
        dout    = addr[0] ? DEV_CODE : MFR_CODE;
        dout_oe = 1'b1;
      end
      default: begin
        dout    = '0;
        dout_oe = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/uvrom_model_chk.sv
module uvrom_model_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int ID_BIT = 9,
  parameter logic [DATA_W-1:0] MFR_CODE = DATA_W'(8'h20),
  parameter logic [DATA_W-1:0] DEV_CODE = DATA_W'(8'h3D)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_hi,
  input logic              id_hv,
  input logic              erase,
  input logic [DATA_W-1:0] dout,
  input logic              dout_oe
);
  localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ID_MASK = ~(ONE | (ONE << ID_BIT));

  logic live_q;
  logic id_sel;
  logic arr_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  assign id_sel   = id_hv && ((addr & ID_MASK) == '0);
  assign arr_read = !ce_n && !oe_n && !vpp_hi && !id_sel;

  // R2
  a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!dout_oe && dout == '0));

  // R4
  a_r4_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && !vpp_hi) |-> !dout_oe);

  // R5
  a_r5_program_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && vpp_hi) |-> !dout_oe);

  // R9
  a_r9_ident_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !vpp_hi && id_sel) |->
      (dout_oe && dout == (addr[0] ? DEV_CODE : MFR_CODE)));

  // R8
  a_r8_erase_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(erase) && arr_read) |-> (dout_oe && dout == '1));

  // R6
  a_r6_bits_never_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && arr_read && $past(arr_read) && $stable(addr) && !$past(erase))
      |-> ((dout & ~$past(dout)) == '0));
endmodule

bind uvrom_model uvrom_model_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_BIT(ID_BIT),
  .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
  .vpp_hi(vpp_hi), .id_hv(id_hv), .erase(erase),
  .dout(dout), .dout_oe(dout_oe)
);

// File: tb/uvrom_model_test.sv
`timescale 1ns/1ps
module uvrom_model_test;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int ID_BIT = 9;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic              ce_n, oe_n, vpp_hi, id_hv, erase;
  logic [DATA_W-1:0] din;
  logic [DATA_W-1:0] dout;
  logic              dout_oe;

  int checks   = 0;
  int failures = 0;
  logic [7:0] shadow [DEPTH];

  always #2.5 clk = ~clk;

  uvrom_model uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .vpp_hi(vpp_hi), .id_hv(id_hv), .erase(erase), .din(din),
    .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic is_id_addr(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] m;
    m = ~((ADDR_W'(1)) | (ADDR_W'(1) << ID_BIT));
    return (a & m) == '0;
  endfunction

  function automatic logic [7:0] id_byte(input logic a0);
    return a0 ? 8'h3D : 8'h20;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0; id_hv = 1'b0; erase = 1'b0;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input string req);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b0; id_hv = 1'b0; addr = a;
    #1;
    chk(req, {7'd0, dout_oe, dout}, {7'd0, 1'b1, shadow[a]});
  endtask

  task automatic do_id(input logic [ADDR_W-1:0] a, input string req);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b0; id_hv = 1'b1; addr = a;
    #1;
    if (is_id_addr(a)) chk(req, {7'd0, dout_oe, dout}, {7'd0, 1'b1, id_byte(a[0])});
    else               chk(req, {7'd0, dout_oe, dout}, {7'd0, 1'b1, shadow[a]});
    id_hv = 1'b0;
  endtask

  task automatic do_prog(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                         input int len, input logic with_erase);
    @(negedge clk);
    addr = a; din = d; vpp_hi = 1'b1; oe_n = 1'b1; id_hv = 1'b0; ce_n = 1'b0;
    #1;
    chk("R5 outputs off during pulse", {15'd0, dout_oe}, 16'd0);
    repeat (len) @(negedge clk);
    ce_n = 1'b1;
    erase = with_erase;
    @(negedge clk);
    vpp_hi = 1'b0; erase = 1'b0;
    if (with_erase) for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
    else            shadow[a] = shadow[a] & d;
  endtask

  task automatic do_erase();
    @(negedge clk);
    idle(); erase = 1'b1;
    @(negedge clk);
    erase = 1'b0;
    for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hFF;
    idle(); addr = '0; din = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 reset outputs off", {7'd0, dout_oe, dout}, 16'd0);
    do_read(10'd0, "R1 erased low byte");
    do_read(10'h3FF, "R1 erased top byte");

    // R2 standby with every other pin exercised
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b0; vpp_hi = 1'b1; id_hv = 1'b1; addr = '0; #1;
    chk("R2 standby ignores others", {7'd0, dout_oe, dout}, 16'd0);
    idle();

    // R3 / R5 / R6 programming
    do_prog(10'd5, 8'hA5, 2, 1'b0);
    do_read(10'd5, "R3 R5 programmed byte");
    do_prog(10'd5, 8'h0F, 1, 1'b0);
    do_read(10'd5, "R6 AND into cell");
    do_prog(10'd5, 8'hFF, 3, 1'b0);
    do_read(10'd5, "R6 ones do not restore");
    do_read(10'd6, "R5 neighbour untouched");

    // R4 output disable
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; vpp_hi = 1'b0; addr = 10'd5; #1;
    chk("R4 output disable", {15'd0, dout_oe}, 16'd0);

    // R7 inhibit: supply up, chip enable high
    @(negedge clk);
    ce_n = 1'b1; vpp_hi = 1'b1; addr = 10'd7; din = 8'h00;
    repeat (3) @(negedge clk);
    vpp_hi = 1'b0;
    do_read(10'd7, "R7 inhibit no write");

    // R7 aborted pulse: supply drops before chip enable rises
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; vpp_hi = 1'b1; addr = 10'd8; din = 8'h00;
    @(negedge clk); vpp_hi = 1'b0;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
    do_read(10'd8, "R7 aborted pulse no write");

    // R9 / R10 identifier
    do_id(10'h000, "R9 maker byte");
    do_id(10'h001, "R9 device byte");
    do_id(10'h201, "R9 select bit itself ignored");
    do_prog(10'h008, 8'h3C, 1, 1'b0);
    do_id(10'h008, "R10 other bit set reads array");
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; vpp_hi = 1'b0; id_hv = 1'b1; addr = 10'h001; #1;
    chk("R4 identifier with output disabled", {15'd0, dout_oe}, 16'd0);
    idle();

    // R8 erase, and erase on the same edge as a commit
    do_erase();
    do_read(10'd5, "R8 erase restores ones");
    do_prog(10'd9, 8'h00, 2, 1'b1);
    do_read(10'd9, "R8 erase wins over commit");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int sel;
      logic [ADDR_W-1:0] ra;
      sel = $urandom_range(0, 9);
      ra  = ADDR_W'($urandom_range(0, DEPTH - 1));
      if (sel <= 3) do_read(ra, "R3 random read");
      else if (sel <= 6) begin
        do_prog(ra, 8'($urandom), $urandom_range(1, 3), 1'b0);
        do_read(ra, "R6 random program");
      end else if (sel == 7) begin
        do_id(($urandom_range(0, 1) == 0) ? ADDR_W'(ra[0]) : ra, "R9 random identifier");
      end else if (sel == 8) begin
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'($urandom); vpp_hi = 1'($urandom); addr = ra; #1;
        chk("R2 random standby", {7'd0, dout_oe, dout}, 16'd0);
        idle();
      end else if ($urandom_range(0, 9) == 0) begin
        do_erase();
        do_read(ra, "R8 random erase");
      end
    end

    // Whole-array sweep after an erase
    do_erase();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b0; vpp_hi = 1'b0; id_hv = 1'b0; addr = ADDR_W'(i); #1;
      if (dout !== 8'hFF || dout_oe !== 1'b1)
        chk("R8 sweep after erase", {7'd0, dout_oe, dout}, {7'd0, 1'b1, 8'hFF});
    end
    chk("R8 sweep done", 16'd1, 16'd1);

    idle();
    @(negedge clk);
    summary();
    $finish;
  end
endmodule